// File: doc/BRIEF.md
# Congestion-Aware Adaptive Output Selector

This block picks the outgoing link for a packet held at one node of a two-dimensional mesh. It first computes a dimension-ordered default (the X offset is closed before the Y offset) from the packet's destination and the node's own coordinates. It also reads a full flag and a half-full flag for the input queue of each of the four neighbours and turns them into a two-bit link code: free, busy or congested.

When the default link is congested, the block looks at the two links perpendicular to the default and takes the first one that is free. If neither is free, it reports a stall. A packet addressed to this node goes to the local port, and the congestion check is skipped. The decision is held in a small state register: SEL_IDLE (no packet), SEL_LOCAL (delivered locally), SEL_DEFAULT (default granted), SEL_ALT_FIRST (first alternative), SEL_ALT_SECOND (second alternative) and SEL_STALL (no link available).

Every cycle the next state is chosen in a fixed priority order:
1. `pkt_valid` low gives SEL_IDLE.
2. A destination equal to the local coordinates gives SEL_LOCAL.
3. A default link that is not congested gives SEL_DEFAULT.
4. A free first alternative gives SEL_ALT_FIRST.
5. A free second alternative gives SEL_ALT_SECOND.
6. Anything else gives SEL_STALL.

Top module: `adaptive_port_select`

## Requirements
- R1: For each direction d, `nb_status[2d+1:2d]` is 2'b10 (congested) when `nb_full[d]` is 1, 2'b01 (busy) when `nb_half[d]` is 1 and `nb_full[d]` is 0, and 2'b00 (free) otherwise. The status is combinational from the inputs.
- R2: Directions use these codes: north 2'b00, east 2'b01, west 2'b10, south 2'b11. Bit index d of `nb_full` and `nb_half` belongs to the direction whose code is d.
- R3: The default direction is east when dest_x > here_x and west when dest_x < here_x. When the X coordinates are equal, it is north when dest_y > here_y and south when dest_y < here_y. Coordinates are unsigned.
- R4: A decision appears on `out_dir`, `out_valid`, `out_stall` and `out_local` one clock edge after the inputs are sampled. The outputs do not change before that edge.
- R5: When the default link is not congested, it is granted (`out_valid`=1, `out_dir`=default), even if the link is busy.
- R6: When the default link is congested, the alternatives are east then west for a north or south default, and north then south for an east or west default. The first alternative is granted if it is free; otherwise the second is granted if it is free.
- R7: When the default link is congested and neither alternative is free, `out_stall`=1, `out_valid`=0, and `out_dir` shows the default.
- R8: When dest equals here, `out_local`=1, `out_valid`=1 and `out_dir`=2'b00, whatever the neighbour status.
- R9: A cycle with `pkt_valid`=0 gives `out_valid`=0, `out_stall`=0 and `out_local`=0 on the next edge.
- R10: During and after reset, `out_valid`, `out_stall`, `out_local` and `out_dir` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| here_x | input | COORD_W | X coordinate of this node |
| here_y | input | COORD_W | Y coordinate of this node |
| pkt_valid | input | 1 | A packet is presented this cycle |
| dest_x | input | COORD_W | Destination X coordinate |
| dest_y | input | COORD_W | Destination Y coordinate |
| nb_full | input | 4 | Neighbour input queue full, one bit per direction code |
| nb_half | input | 4 | Neighbour input queue half full, one bit per direction code |
| nb_status | output | 8 | Two-bit link code per direction |
| out_dir | output | 2 | Selected direction |
| out_local | output | 1 | Packet delivered to the local port |
| out_valid | output | 1 | A link or the local port was granted |
| out_stall | output | 1 | No link available; packet must wait |

## Verification
The bench builds the block with the default 4-bit coordinates and places the node at (5,9), away from the edges. It sends destinations from the 3-by-3 neighbourhood of the node against all 256 combinations of the full and half-full flags. That covers every default direction and every congested, busy or free mix on the default and on both alternatives. Extra runs with the node at (0,0) and (15,15) and the destination at the opposite corner test the unsigned comparison at the extremes of the coordinate range.

// File: rtl/adsel_pkg.sv
package adsel_pkg;

    localparam int NUM_DIRS = 4;
    localparam int LINK_W   = 2;

    typedef enum logic [1:0] {
        DIR_N = 2'b00,
        DIR_E = 2'b01,
        DIR_W = 2'b10,
        DIR_S = 2'b11
    } dir_t;

    typedef enum logic [1:0] {
        LNK_FREE = 2'b00,
        LNK_BUSY = 2'b01,
        LNK_CONG = 2'b10
    } link_t;

    typedef enum logic [2:0] {
        SEL_IDLE,
        SEL_LOCAL,
        SEL_DEFAULT,
        SEL_ALT_FIRST,
        SEL_ALT_SECOND,
        SEL_STALL
    } sel_state_t;

endpackage

// File: rtl/adsel_link_status.sv
module adsel_link_status
    import adsel_pkg::*;
#(
    parameter int NUM = NUM_DIRS
) (
    input  logic [NUM-1:0]        full,
    input  logic [NUM-1:0]        half,
    output logic [LINK_W*NUM-1:0] code
);

    genvar d;
    generate
        for (d = 0; d < NUM; d++) begin : g_link
            // A full queue overrides the half-full flag.
            always_comb begin
                if (full[d])      code[LINK_W*d +: LINK_W] = LNK_CONG;
                else if (half[d]) code[LINK_W*d +: LINK_W] = LNK_BUSY;
                else              code[LINK_W*d +: LINK_W] = LNK_FREE;
            end
        end
    endgenerate

endmodule

// File: rtl/adsel_xy.sv
module adsel_xy
    import adsel_pkg::*;
#(
    parameter int CW = 4
) (
    input  logic [CW-1:0] here_x,
    input  logic [CW-1:0] here_y,
    input  logic [CW-1:0] dest_x,
    input  logic [CW-1:0] dest_y,
    output dir_t          dflt,
    output logic          at_home
);

    always_comb begin
        at_home = (dest_x == here_x) && (dest_y == here_y);
        if (dest_x > here_x)      dflt = DIR_E;
        else if (dest_x < here_x) dflt = DIR_W;
        else if (dest_y > here_y) dflt = DIR_N;
        else                      dflt = DIR_S;
    end

endmodule

// File: rtl/adsel_alt_pick.sv
module adsel_alt_pick
    import adsel_pkg::*;
(
    input  dir_t                       dflt,
    input  logic [LINK_W*NUM_DIRS-1:0] code,
    output dir_t                       alt_a,
    output dir_t                       alt_b,
    output logic                       dflt_cong,
    output logic                       a_free,
    output logic                       b_free
);

    logic [LINK_W-1:0] code_d, code_a, code_b;

    // The alternatives are the two links perpendicular to the default.
    always_comb begin
        unique case (dflt)
            DIR_N, DIR_S: begin alt_a = DIR_E; alt_b = DIR_W; end
            default:      begin alt_a = DIR_N; alt_b = DIR_S; end
        endcase
    end

    // Three readers of the link codes, each selected by one direction.
    always_comb begin
        code_d    = code[LINK_W*dflt  +: LINK_W];
        code_a    = code[LINK_W*alt_a +: LINK_W];
        code_b    = code[LINK_W*alt_b +: LINK_W];
        dflt_cong = (code_d == LNK_CONG);
        a_free    = (code_a == LNK_FREE);
        b_free    = (code_b == LNK_FREE);
    end

endmodule

// File: rtl/adaptive_port_select.sv
module adaptive_port_select
    import adsel_pkg::*;
#(
    parameter int COORD_W = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [COORD_W-1:0]         here_x,
    input  logic [COORD_W-1:0]         here_y,
    input  logic                       pkt_valid,
    input  logic [COORD_W-1:0]         dest_x,
    input  logic [COORD_W-1:0]         dest_y,
    input  logic [NUM_DIRS-1:0]        nb_full,
    input  logic [NUM_DIRS-1:0]        nb_half,
    output logic [LINK_W*NUM_DIRS-1:0] nb_status,
    output logic [1:0]                 out_dir,
    output logic                       out_local,
    output logic                       out_valid,
    output logic                       out_stall
);

    sel_state_t state_q, state_d;
    dir_t       dir_q, dir_d;
    dir_t       dflt, alt_a, alt_b;
    logic       at_home, dflt_cong, a_free, b_free;

    adsel_link_status #(.NUM(NUM_DIRS)) u_status (
        .full (nb_full),
        .half (nb_half),
        .code (nb_status)
    );

    adsel_xy #(.CW(COORD_W)) u_xy (
        .here_x  (here_x),
        .here_y  (here_y),
        .dest_x  (dest_x),
        .dest_y  (dest_y),
        .dflt    (dflt),
        .at_home (at_home)
    );

    adsel_alt_pick u_alt (
        .dflt      (dflt),
        .code      (nb_status),
        .alt_a     (alt_a),
        .alt_b     (alt_b),
        .dflt_cong (dflt_cong),
        .a_free    (a_free),
        .b_free    (b_free)
    );

    // Next-state selection, in priority order.
    always_comb begin
        if (!pkt_valid) begin
            state_d = SEL_IDLE;       dir_d = DIR_N;
        end else if (at_home) begin
            state_d = SEL_LOCAL;      dir_d = DIR_N;
        end else if (!dflt_cong) begin
            state_d = SEL_DEFAULT;    dir_d = dflt;
        end else if (a_free) begin
            state_d = SEL_ALT_FIRST;  dir_d = alt_a;
        end else if (b_free) begin
            state_d = SEL_ALT_SECOND; dir_d = alt_b;
        end else begin
            state_d = SEL_STALL;      dir_d = dflt;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEL_IDLE;
            dir_q   <= DIR_N;
        end else begin
            state_q <= state_d;
            dir_q   <= dir_d;
        end
    end

    // Outputs decoded from the held state.
    always_comb begin
        out_dir   = dir_q;
        out_local = 1'b0;
        out_valid = 1'b0;
        out_stall = 1'b0;
        unique case (state_q)
            SEL_IDLE:       ;
            SEL_LOCAL:      begin out_local = 1'b1; out_valid = 1'b1; end
            SEL_DEFAULT,
            SEL_ALT_FIRST,
            SEL_ALT_SECOND: out_valid = 1'b1;
            SEL_STALL:      out_stall = 1'b1;
            default:        ;
        endcase
    end

    // Checks. full_seen holds the full flags from the cycle that was decided.
    logic [NUM_DIRS-1:0] full_seen;
    always_ff @(posedge clk) full_seen <= nb_full;

    assert_no_grant_into_full_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_local && $past(rst_n)) |-> !full_seen[out_dir]);

    assert_idle_after_no_packet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(pkt_valid)) |-> (!out_valid && !out_stall && !out_local));

    assert_valid_stall_exclusive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && out_stall));

    assert_local_is_granted_R8: assert property (@(posedge clk) disable iff (!rst_n)
        out_local |-> (out_valid && out_dir == 2'b00));

    assert_stall_needs_full_default_R7: assert property (@(posedge clk) disable iff (!rst_n)
        out_stall |-> full_seen[out_dir]);

endmodule

// File: tb/adaptive_port_select_test.sv
`timescale 1ns/1ps
module adaptive_port_select_test;

    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] here_x = '0, here_y = '0, dest_x = '0, dest_y = '0;
    logic          pkt_valid = 1'b0;
    logic [3:0]    nb_full = '0, nb_half = '0;
    logic [7:0]    nb_status;
    logic [1:0]    out_dir;
    logic          out_local, out_valid, out_stall;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    adaptive_port_select #(.COORD_W(CW)) uut (
        .clk(clk), .rst_n(rst_n), .here_x(here_x), .here_y(here_y),
        .pkt_valid(pkt_valid), .dest_x(dest_x), .dest_y(dest_y),
        .nb_full(nb_full), .nb_half(nb_half), .nb_status(nb_status),
        .out_dir(out_dir), .out_local(out_local), .out_valid(out_valid),
        .out_stall(out_stall)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int link_code(input int d, input logic [3:0] f, input logic [3:0] h);
        if (f[d]) return 2;
        if (h[d]) return 1;
        return 0;
    endfunction

    // Direction codes: N=0 E=1 W=2 S=3.
    function automatic int xy_dir(input int hx, input int hy, input int dx, input int dy);
        if (dx > hx) return 1;
        if (dx < hx) return 2;
        if (dy > hy) return 0;
        return 3;
    endfunction

    // Packed result {kind, dir}; kind 0=idle 1=local 2=granted 3=stall.
    function automatic int model(input int hx, input int hy, input int dx, input int dy,
                                 input logic [3:0] f, input logic [3:0] h);
        int d, a, b;
        if (dx == hx && dy == hy) return 1 * 4 + 0;
        d = xy_dir(hx, hy, dx, dy);
        if (link_code(d, f, h) != 2) return 2 * 4 + d;
        a = (d == 0 || d == 3) ? 1 : 0;
        b = (d == 0 || d == 3) ? 2 : 3;
        if (link_code(a, f, h) == 0) return 2 * 4 + a;
        if (link_code(b, f, h) == 0) return 2 * 4 + b;
        return 3 * 4 + d;
    endfunction

    task automatic send(input int hx, input int hy, input int dx, input int dy,
                        input logic [3:0] f, input logic [3:0] h);
        int exp, kind, act;
        string tag;
        @(negedge clk);
        here_x = CW'(hx); here_y = CW'(hy); dest_x = CW'(dx); dest_y = CW'(dy);
        nb_full = f; nb_half = h; pkt_valid = 1'b1;
        #1;
        for (int d = 0; d < 4; d++) begin
            // R1: status code per direction
            check(int'(nb_status[2*d +: 2]) == link_code(d, f, h), "R1 status",
                  int'(nb_status[2*d +: 2]), link_code(d, f, h));
        end
        @(posedge clk);
        @(negedge clk);
        exp  = model(hx, hy, dx, dy, f, h);
        kind = exp / 4;
        act  = (out_local ? 4 : 0) + (out_valid ? 2 : 0) + (out_stall ? 1 : 0);
        if (kind == 1) tag = "R8 local";
        else if (kind == 3) tag = "R7 stall";
        else if ((exp % 4) == xy_dir(hx, hy, dx, dy)) tag = "R5 default";
        else tag = "R6 alternative";
        check(act == (kind == 1 ? 6 : kind == 2 ? 2 : 1), {tag, " flags"}, act,
              (kind == 1 ? 6 : kind == 2 ? 2 : 1));
        check(int'(out_dir) == exp % 4, {tag, " dir"}, int'(out_dir), exp % 4);
        if (f == 4'h0 && kind != 1)
            // R2 and R3: plain XY direction when nothing is congested
            check(int'(out_dir) == xy_dir(hx, hy, dx, dy), "R2 R3 xy", int'(out_dir),
                  xy_dir(hx, hy, dx, dy));
    endtask

    initial begin
        #(20 * 200000);
        n_errors++;
        n_checks++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        check({out_valid, out_stall, out_local, out_dir} == 5'b0, "R10 reset",
              int'({out_valid, out_stall, out_local, out_dir}), 0);
        rst_n = 1'b1;

        // R4: output waits for the clock edge
        @(negedge clk);
        here_x = 4'd5; here_y = 4'd9; dest_x = 4'd6; dest_y = 4'd9;
        nb_full = '0; nb_half = '0; pkt_valid = 1'b1;
        #5;
        check(!out_valid, "R4 before edge", int'(out_valid), 0);
        @(negedge clk);
        check(out_valid && out_dir == 2'b01, "R4 after edge",
              int'({out_valid, out_dir}), 5);

        for (int dx = 4; dx <= 6; dx++)
            for (int dy = 8; dy <= 10; dy++)
                for (int f = 0; f < 16; f++)
                    for (int h = 0; h < 16; h++)
                        send(5, 9, dx, dy, 4'(f), 4'(h));

        // Coordinate extremes
        send(0, 0, 15, 15, 4'h0, 4'h0);
        send(15, 15, 0, 0, 4'h0, 4'h0);
        send(0, 0, 0, 15, 4'h0, 4'h0);
        send(15, 15, 15, 0, 4'h0, 4'h0);
        send(0, 0, 0, 0, 4'hF, 4'hF);

        // R9: no packet means idle, even with every link full
        @(negedge clk);
        pkt_valid = 1'b0; nb_full = 4'hF; dest_x = 4'd6;
        @(negedge clk);
        check(!out_valid && !out_stall && !out_local, "R9 idle",
              int'({out_local, out_valid, out_stall}), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule